// File: doc/BRIEF.md
# Pairwise-Order Replacement State Unit

This block holds the replacement state for a set-associative cache of one to four ways. For every set it stores one ordering bit for each pair of ways. A set bit means the lower-numbered way of the pair is the more recent one. A clear bit means it is the older one. These bits always describe a total order of the ways, and the victim is the way that is older than every other way in that order.

Two independent paths use the state. A lookup reads one set and reports the victim way one cycle later; it is used when a line is allocated. An update takes only the way number and an event kind and produces fresh bit values plus a per-bit write mask. The state is then written through that mask, so no read of the old bits is needed. Hits and allocations make the way the newest. Invalidations make it the oldest. Setting the FIFO mode input suppresses the mask on hits, so that only allocations change the order. This turns the policy into first-in first-out.

Top module: `plru_repl`

## Requirements
- R1: After reset every state bit of every set is 0, so a lookup on any set names way 0 and `victim_vld` is low while reset is held.
- R2: An update of kind hit (`upd_kind`=0) or allocate (`upd_kind`=1) on way w < WAYS enables in `wr_mask` exactly the pair bits that involve w. For pair (i,j) with i<j, the bit index is 0 for (0,1), 1 for (0,2), 2 for (0,3), 3 for (1,2), 4 for (1,3) and 5 for (2,3). The written value is 1 when i equals w and 0 when j equals w, which makes w newer than all other ways.
- R3: An update of kind invalidate (`upd_kind`=2) on way w enables the same pair bits as R2, but the written value is 1 when j equals w and 0 when i equals w, which makes w older than all other ways.
- R4: With `fifo_mode` high, a hit produces an all-zero `wr_mask` and leaves the order unchanged. Allocate and invalidate behave as in R2 and R3 regardless of the mode.
- R5: The victim reported for a set is the way that was least recently made newest by a hit (LRU mode) or an allocation, taking invalidations into account as making a way oldest.
- R6: `victim` and `victim_vld` are valid exactly one clock after `look_en` is sampled high; `victim_vld` is low in every cycle that does not follow a lookup.
- R7: A lookup and an update to the same set in the same cycle yield the victim computed from the state before that update; the update is visible to the next lookup.
- R8: With WAYS=1 the victim is always way 0 and `wr_mask` is always 0; kind 3 and a way number of WAYS or above produce a zero mask for any WAYS.
- R9: An update changes only the addressed set; the victims of all other sets stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1: hits do not update the order |
| look_en | input | 1 | Start a victim lookup |
| look_set | input | SETW | Set index for the lookup |
| victim | output | 2 | Victim way, valid with victim_vld |
| victim_vld | output | 1 | Victim output valid |
| upd_en | input | 1 | Apply an update this cycle |
| upd_set | input | SETW | Set index for the update |
| upd_way | input | 2 | Way accessed by the update |
| upd_kind | input | 2 | 0 hit, 1 allocate, 2 invalidate, 3 none |
| wr_bits | output | 6 | Encoded new pair bits |
| wr_mask | output | 6 | Per-bit write enable for the pair bits |

## Verification
A lookup and an update can fall in the same cycle, and the sharpest case is when they address the same set: the lookup must see the order as it was before the masked write lands. The bench provokes this by raising both strobes on one falling edge with equal set indices. It compares the reported victim against the age model taken before the update. A later lookup must then return the victim from the model taken after the update.

// File: rtl/plru_repl.sv
module plru_repl #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int SETW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_mode,
  input  logic            look_en,
  input  logic [SETW-1:0] look_set,
  output logic [1:0]      victim,
  output logic            victim_vld,
  input  logic            upd_en,
  input  logic [SETW-1:0] upd_set,
  input  logic [1:0]      upd_way,
  input  logic [1:0]      upd_kind,
  output logic [5:0]      wr_bits,
  output logic [5:0]      wr_mask
);
  localparam int MAXW = 4;
  localparam logic [1:0] K_HIT = 2'd0;
  localparam logic [1:0] K_INV = 2'd2;
  localparam logic [1:0] K_NONE = 2'd3;

  logic [5:0] st [SETS];
  logic [5:0] rd;
  logic [MAXW-1:0] older, older_q;

  always_comb begin
    int k;
    k = 0;
    wr_bits = '0;
    wr_mask = '0;
    for (int i = 0; i < MAXW; i++)
      for (int j = i + 1; j < MAXW; j++) begin
        if (j < WAYS && upd_en && upd_kind != K_NONE &&
            (int'(upd_way) == i || int'(upd_way) == j)) begin
          wr_mask[k] = !(fifo_mode && upd_kind == K_HIT);
          wr_bits[k] = (upd_kind == K_INV) ? (int'(upd_way) == j) : (int'(upd_way) == i);
        end
        k++;
      end
  end

  assign rd = st[look_set];

  always_comb begin
    int k;
    k = 0;
    for (int w = 0; w < MAXW; w++) older[w] = (w < WAYS);
    for (int i = 0; i < MAXW; i++)
      for (int j = i + 1; j < MAXW; j++) begin
        if (j < WAYS) begin
          if (rd[k]) older[i] = 1'b0;
          else       older[j] = 1'b0;
        end
        k++;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st[s] <= '0;
      victim_vld <= 1'b0;
      victim     <= '0;
      older_q    <= '0;
    end else begin
      if (upd_en) st[upd_set] <= (st[upd_set] & ~wr_mask) | (wr_bits & wr_mask);
      victim_vld <= look_en;
      if (look_en) begin
        older_q <= older;
        victim  <= older[0] ? 2'd0 : older[1] ? 2'd1 : older[2] ? 2'd2 : 2'd3;
      end
    end
  end

  a_r6_victim_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    look_en |=> victim_vld);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !look_en |=> !victim_vld);
  a_r5_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> $countones(older_q) == 1);
  a_r4_fifo_hit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && fifo_mode && upd_kind == K_HIT) |-> wr_mask == 6'd0);
  a_r2_alloc_mask_size: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_kind == 2'd1 && int'(upd_way) < WAYS) |-> $countones(wr_mask) == WAYS - 1);
  a_r8_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> int'(victim) < WAYS);
endmodule

// File: tb/plru_repl_tb_top.sv
module plru_repl_tb_top;
  localparam int SETS = 16;
  localparam int SETW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, look_en = 1'b0, upd_en = 1'b0;
  logic [SETW-1:0] look_set = '0, upd_set = '0;
  logic [1:0] upd_way = '0, upd_kind = '0;
  logic [1:0] victim, victim1;
  logic victim_vld, victim_vld1;
  logic [5:0] wr_bits, wr_mask, wr_bits1, wr_mask1;

  int checks = 0, fails = 0;
  int age [SETS][4];
  int tick = 10;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  plru_repl #(.WAYS(4), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .look_en(look_en), .look_set(look_set),
    .victim(victim), .victim_vld(victim_vld), .upd_en(upd_en), .upd_set(upd_set),
    .upd_way(upd_way), .upd_kind(upd_kind), .wr_bits(wr_bits), .wr_mask(wr_mask));

  plru_repl #(.WAYS(1), .SETS(SETS)) dut1_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .look_en(look_en), .look_set(look_set),
    .victim(victim1), .victim_vld(victim_vld1), .upd_en(upd_en), .upd_set(upd_set),
    .upd_way(upd_way), .upd_kind(upd_kind), .wr_bits(wr_bits1), .wr_mask(wr_mask1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_victim(input int s);
    int v = 0;
    for (int w = 1; w < 4; w++) if (age[s][w] < age[s][v]) v = w;
    return v;
  endfunction

  function automatic void model_upd(input int s, input int w, input int kind, input bit fifo);
    int mn;
    if (w > 3) return;
    if (kind == 1 || (kind == 0 && !fifo)) begin
      tick++;
      age[s][w] = tick;
    end else if (kind == 2) begin
      mn = age[s][0];
      for (int x = 1; x < 4; x++) if (age[s][x] < mn) mn = age[s][x];
      age[s][w] = mn - 1;
    end
  endfunction

  function automatic void exp_enc(input int nways, input int w, input int kind, input bit fifo,
                                  output logic [5:0] eb, output logic [5:0] em);
    int k = 0;
    eb = '0;
    em = '0;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++) begin
        if (j < nways && kind != 3 && (w == i || w == j) && !(fifo && kind == 0)) begin
          em[k] = 1'b1;
          eb[k] = (kind == 2) ? (w == j) : (w == i);
        end
        k++;
      end
  endfunction

  task automatic do_upd(input int s, input int w, input int kind, input bit fifo);
    logic [5:0] eb, em;
    @(negedge clk);
    upd_en = 1'b1; upd_set = s[SETW-1:0]; upd_way = w[1:0]; upd_kind = kind[1:0]; fifo_mode = fifo;
    #1;
    exp_enc(4, w, kind, fifo, eb, em);
    chk(wr_mask == em, (kind == 2) ? "R3 mask" : (fifo && kind == 0) ? "R4 mask" : "R2 mask", wr_mask, em);
    chk((wr_bits & wr_mask) == eb, (kind == 2) ? "R3 bits" : "R2 bits", wr_bits & wr_mask, eb);
    chk(wr_mask1 == 6'd0, "R8 one-way mask", wr_mask1, 0);
    @(negedge clk);
    upd_en = 1'b0;
    model_upd(s, w, kind, fifo);
  endtask

  task automatic do_look(input int s, input string tag);
    int ev;
    @(negedge clk);
    look_en = 1'b1; look_set = s[SETW-1:0];
    @(negedge clk);
    look_en = 1'b0;
    ev = model_victim(s);
    chk(victim_vld == 1'b1, "R6 valid", victim_vld, 1);
    chk(int'(victim) == ev, tag, victim, ev);
    chk(victim1 == 2'd0, "R8 one-way victim", victim1, 0);
    @(negedge clk);
    chk(victim_vld == 1'b0, "R6 valid drop", victim_vld, 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < 4; w++) age[s][w] = w;
    repeat (3) @(negedge clk);
    chk(victim_vld == 1'b0, "R1 valid in reset", victim_vld, 0);
    rst_n = 1'b1;
    for (int s = 0; s < SETS; s++) do_look(s, "R1 reset victim");

    for (int f = 0; f < 2; f++)
      for (int kind = 0; kind < 4; kind++)
        for (int w = 0; w < 4; w++) begin
          do_upd(0, w, kind, f[0]);
          do_look(0, f ? "R4 fifo victim" : "R5 victim");
          do_look(1, "R9 untouched set");
        end

    for (int n = 0; n < 300; n++) begin
      int s, w, kind;
      bit f;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = int'(lfsr[3:0]);
      w = int'(lfsr[5:4]);
      kind = (lfsr[7:6] == 2'd3) ? 1 : int'(lfsr[7:6]);
      f = lfsr[11] & lfsr[9];
      do_upd(s, w, kind, f);
      do_look(s, "R5 victim");
      do_look(s ^ 5, "R9 other set");
    end

    do_upd(2, 4 - 1, 3, 1'b0);
    do_look(2, "R8 none kind");

    for (int n = 0; n < 16; n++) begin
      int pre, w;
      w = n % 4;
      @(negedge clk);
      pre = model_victim(n);
      look_en = 1'b1; look_set = n[SETW-1:0];
      upd_en = 1'b1; upd_set = n[SETW-1:0]; upd_way = w[1:0]; upd_kind = 2'd1; fifo_mode = 1'b0;
      @(negedge clk);
      look_en = 1'b0; upd_en = 1'b0;
      chk(int'(victim) == pre, "R7 same-cycle pre-write", victim, pre);
      model_upd(n, w, 1, 1'b0);
      do_look(n, "R7 post-write");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule